// File: doc/BRIEF.md
# Interlaced SD Raster Timing Generator

This block produces the raster timing for interlaced standard-definition video from a single pixel clock. A pixel counter and a line counter trace the frame. From these the block decodes a horizontal sync pulse, a vertical sync pulse at the top of each field, a field flag and an active-video flag, all of them registered. The counters themselves are exposed as raster coordinates.

A mode input selects one of two built-in standards: 525 lines at 60 Hz, or 625 lines at 50 Hz. An override input replaces the built-in standard with values on a set of configuration ports: frame length, field-2 start line, line width, first active pixel, active width, active height per field, and active-line offset within a field. Mode, override and configuration values are captured only at the last pixel of a frame, so a running frame is never torn. A synchronous reset restarts the raster at its origin and loads the configuration presented during reset. Every port is a plain level; there is no data stream and no handshake. The configuration ports must describe a raster that fits: both windows inside the frame, line width of at least 2, field 2 starting after field 1's active window.

Top module: `sd_raster_gen`

## Requirements
- R1: `pix_x` counts 0 to line width minus 1 and wraps to 0. `pix_y` counts from 1 to frame length and advances by one only when `pix_x` wraps. After the last pixel of line frame-length, it returns to 1.
- R2: `field` is 0 while `pix_y` is below the field-2 start line and 1 from that line to the end of the frame.
- R3: `active` is 1 exactly when two conditions hold. First, `pix_x` lies in [active start, active start + active width). Second, `pix_y` lies either in [offset, offset + height) or in [field-2 start + offset, field-2 start + offset + height).
- R4: `hsync` is 1 exactly when `pix_x` < HSYNC_W. The default of HSYNC_W is 64.
- R5: `vsync` is 1 for the first VSYNC_LINES lines of each field: lines 1 to VSYNC_LINES, and field-2 start to field-2 start + VSYNC_LINES - 1. The default of VSYNC_LINES is 3.
- R6: With `cfg_override`=0 and `mode_625`=0, the 525/60 raster is used:
  - frame length 525, field-2 start 264;
  - line width 858, active start 138, active width 720;
  - height 240, offset 20.
- R7: With `cfg_override`=0 and `mode_625`=1, the 625/50 raster is used:
  - frame length 625, field-2 start 311;
  - line width 864, active start 144, active width 720;
  - height 288, offset 23.
- R8: With `cfg_override`=1, the raster takes its seven values from the `cfg_*` ports.
- R9: `mode_625`, `cfg_override` and `cfg_*` are sampled only on the clock edge that ends the last pixel of the last line, and on reset edges. A change at any other time has no effect on the outputs until that edge.
- R10: While `rst_n` is low, each clock edge sets the raster to `pix_x`=0 and `pix_y`=1. The decoded outputs at that point use the configuration present at the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_625 | input | 1 | 0 selects 525/60, 1 selects 625/50 |
| cfg_override | input | 1 | 1 uses the cfg_* ports instead of a built-in standard |
| cfg_frame_len | input | 11 | Lines per frame |
| cfg_f2_start | input | 11 | First line of field 2 |
| cfg_line_width | input | 11 | Pixel clocks per line |
| cfg_act_start | input | 11 | First active pixel of a line |
| cfg_act_width | input | 11 | Active pixels per line |
| cfg_act_height | input | 11 | Active lines per field |
| cfg_line_off | input | 11 | Active-line offset within a field |
| hsync | output | 1 | Horizontal sync, high at the start of each line |
| vsync | output | 1 | Vertical sync, high at the start of each field |
| field | output | 1 | 0 in field 1, 1 in field 2 |
| active | output | 1 | Active picture area |
| pix_x | output | 11 | Pixel position in the line |
| pix_y | output | 11 | Line number in the frame, from 1 |

## Verification
A corrupted pixel or line counter shows at once on `pix_x` or `pix_y`. It also shows within one line on `hsync` and `active`, because these are decoded from the same count. A wrong captured configuration shows as a wrap at the wrong `pix_x` within one line, or as `active` rising at the wrong pixel. A field decode fault appears at the field-2 start line. A capture that ignores the frame boundary shows as a line width that changes mid-frame, seen on the very next line.

// File: rtl/sd_raster_pkg.sv
package sd_raster_pkg;
  parameter int CW = 11;
  typedef logic [CW-1:0] cnt_t;

  typedef struct packed {
    cnt_t frame_len;
    cnt_t f2_start;
    cnt_t line_width;
    cnt_t act_start;
    cnt_t act_width;
    cnt_t act_height;
    cnt_t line_off;
  } raster_cfg_t;

  // Built-in broadcast rasters.
  function automatic raster_cfg_t std_cfg(input logic is_625);
    raster_cfg_t c;
    if (is_625) begin
      c.frame_len  = cnt_t'(625);
      c.f2_start   = cnt_t'(311);
      c.line_width = cnt_t'(864);
      c.act_start  = cnt_t'(144);
      c.act_width  = cnt_t'(720);
      c.act_height = cnt_t'(288);
      c.line_off   = cnt_t'(23);
    end else begin
      c.frame_len  = cnt_t'(525);
      c.f2_start   = cnt_t'(264);
      c.line_width = cnt_t'(858);
      c.act_start  = cnt_t'(138);
      c.act_width  = cnt_t'(720);
      c.act_height = cnt_t'(240);
      c.line_off   = cnt_t'(20);
    end
    return c;
  endfunction
endpackage

// File: rtl/sd_raster_cfg_sel.sv
module sd_raster_cfg_sel
  import sd_raster_pkg::*;
(
  input  logic        mode_625,
  input  logic        cfg_override,
  input  raster_cfg_t cfg_custom,
  output raster_cfg_t cfg_sel
);
  raster_cfg_t std_c;

  always_comb begin
    std_c   = std_cfg(mode_625);
    cfg_sel = cfg_override ? cfg_custom : std_c;
  end
endmodule

// File: rtl/sd_raster_counter.sv
module sd_raster_counter
  import sd_raster_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cnt_t line_width,
  input  cnt_t frame_len,
  output cnt_t hc_q,
  output cnt_t vc_q,
  output cnt_t hc_nxt,
  output cnt_t vc_nxt,
  output logic frame_end
);
  logic line_end;

  always_comb begin
    line_end  = (hc_q == cnt_t'(line_width - cnt_t'(1)));
    frame_end = line_end && (vc_q == frame_len);
    if (!rst_n || frame_end) begin
      hc_nxt = '0;
      vc_nxt = cnt_t'(1);
    end else if (line_end) begin
      hc_nxt = '0;
      vc_nxt = cnt_t'(vc_q + cnt_t'(1));
    end else begin
      hc_nxt = cnt_t'(hc_q + cnt_t'(1));
      vc_nxt = vc_q;
    end
  end

  always_ff @(posedge clk) begin
    hc_q <= hc_nxt;
    vc_q <= vc_nxt;
  end
endmodule

// File: rtl/sd_raster_decode.sv
module sd_raster_decode
  import sd_raster_pkg::*;
#(
  parameter int HSYNC_W     = 64,
  parameter int VSYNC_LINES = 3
)(
  input  cnt_t        hc,
  input  cnt_t        vc,
  input  raster_cfg_t cfg,
  output logic        hsync,
  output logic        vsync,
  output logic        field,
  output logic        active
);
  localparam int EW = CW + 1;
  typedef logic [EW-1:0] ext_t;

  ext_t hc_e, vc_e;
  logic [1:0] vs_hit;
  logic [1:0] va_hit;
  logic       h_act;

  assign hc_e = {1'b0, hc};
  assign vc_e = {1'b0, vc};

  // One sync window and one active window per field.
  for (genvar g = 0; g < 2; g++) begin : g_field
    ext_t vs_base, va_base;
    if (g == 0) begin : g_f1
      assign vs_base = ext_t'(1);
      assign va_base = {1'b0, cfg.line_off};
    end else begin : g_f2
      assign vs_base = {1'b0, cfg.f2_start};
      assign va_base = ext_t'({1'b0, cfg.f2_start} + {1'b0, cfg.line_off});
    end
    assign vs_hit[g] = (vc_e >= vs_base) &&
                       (vc_e < ext_t'(vs_base + ext_t'(VSYNC_LINES)));
    assign va_hit[g] = (vc_e >= va_base) &&
                       (vc_e < ext_t'(va_base + {1'b0, cfg.act_height}));
  end

  always_comb begin
    h_act  = (hc_e >= {1'b0, cfg.act_start}) &&
             (hc_e < ext_t'({1'b0, cfg.act_start} + {1'b0, cfg.act_width}));
    hsync  = hc_e < ext_t'(HSYNC_W);
    vsync  = |vs_hit;
    field  = vc_e >= {1'b0, cfg.f2_start};
    active = h_act && (|va_hit);
  end
endmodule

// File: rtl/sd_raster_gen.sv
module sd_raster_gen
  import sd_raster_pkg::*;
#(
  parameter int HSYNC_W     = 64,
  parameter int VSYNC_LINES = 3
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_625,
  input  logic          cfg_override,
  input  logic [CW-1:0] cfg_frame_len,
  input  logic [CW-1:0] cfg_f2_start,
  input  logic [CW-1:0] cfg_line_width,
  input  logic [CW-1:0] cfg_act_start,
  input  logic [CW-1:0] cfg_act_width,
  input  logic [CW-1:0] cfg_act_height,
  input  logic [CW-1:0] cfg_line_off,
  output logic          hsync,
  output logic          vsync,
  output logic          field,
  output logic          active,
  output logic [CW-1:0] pix_x,
  output logic [CW-1:0] pix_y
);
  raster_cfg_t cfg_custom, cfg_sel, cfg_q, cfg_nxt;
  cnt_t        hc_q, vc_q, hc_nxt, vc_nxt;
  logic        frame_end;
  logic        d_hs, d_vs, d_fld, d_act;

  assign cfg_custom = '{frame_len:  cfg_frame_len,  f2_start:   cfg_f2_start,
                        line_width: cfg_line_width, act_start:  cfg_act_start,
                        act_width:  cfg_act_width,  act_height: cfg_act_height,
                        line_off:   cfg_line_off};

  sd_raster_cfg_sel u_sel (
    .mode_625     (mode_625),
    .cfg_override (cfg_override),
    .cfg_custom   (cfg_custom),
    .cfg_sel      (cfg_sel)
  );

  sd_raster_counter u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_width (cfg_q.line_width),
    .frame_len  (cfg_q.frame_len),
    .hc_q       (hc_q),
    .vc_q       (vc_q),
    .hc_nxt     (hc_nxt),
    .vc_nxt     (vc_nxt),
    .frame_end  (frame_end)
  );

  // The configuration is captured only at a frame boundary or on reset.
  assign cfg_nxt = (!rst_n || frame_end) ? cfg_sel : cfg_q;

  sd_raster_decode #(.HSYNC_W(HSYNC_W), .VSYNC_LINES(VSYNC_LINES)) u_dec (
    .hc     (hc_nxt),
    .vc     (vc_nxt),
    .cfg    (cfg_nxt),
    .hsync  (d_hs),
    .vsync  (d_vs),
    .field  (d_fld),
    .active (d_act)
  );

  // Decoding the next count keeps every output aligned with pix_x and pix_y.
  always_ff @(posedge clk) begin
    cfg_q  <= cfg_nxt;
    hsync  <= d_hs;
    vsync  <= d_vs;
    field  <= d_fld;
    active <= d_act;
  end

  assign pix_x = hc_q;
  assign pix_y = vc_q;
endmodule

// File: rtl/sd_raster_chk.sv
module sd_raster_chk
  import sd_raster_pkg::*;
#(
  parameter int HSYNC_W = 64
)(
  input logic        clk,
  input logic        rst_n,
  input cnt_t        hc,
  input cnt_t        vc,
  input logic        hsync,
  input logic        vsync,
  input logic        field,
  input logic        active,
  input raster_cfg_t cfg_q
);
  logic started = 1'b0;
  always_ff @(posedge clk) started <= 1'b1;

  p_pix_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (hc != '0) |-> (hc == cnt_t'($past(hc) + cnt_t'(1))));

  p_line_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (hc != '0) |-> $stable(vc));

  p_field_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(field) |-> (vc == cfg_q.f2_start));

  p_field_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(field) |-> (vc == cnt_t'(1)));

  p_active_span_r3: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> ({1'b0, hc} >= {1'b0, cfg_q.act_start} &&
                {1'b0, hc} < ({1'b0, cfg_q.act_start} + {1'b0, cfg_q.act_width})));

  p_hsync_span_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hsync == ({1'b0, hc} < (CW+1)'(HSYNC_W)));

  p_vsync_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vsync) |-> (vc == cnt_t'(1) || vc == cfg_q.f2_start));

  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(hc == '0 && vc == cnt_t'(1)) |-> $stable(cfg_q));

  p_reset_origin_r10: assert property (@(posedge clk)
    (started && !$past(rst_n)) |-> (hc == '0 && vc == cnt_t'(1)));
endmodule

bind sd_raster_gen sd_raster_chk #(.HSYNC_W(HSYNC_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .hc     (pix_x),
  .vc     (pix_y),
  .hsync  (hsync),
  .vsync  (vsync),
  .field  (field),
  .active (active),
  .cfg_q  (cfg_q)
);

// File: tb/sd_raster_gen_tb.sv
`timescale 1ns/1ps
module sd_raster_gen_tb;
  localparam int HS_W = 8;
  localparam int VS_L = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_625 = 1'b0, cfg_override = 1'b0;
  logic [10:0] c_len = 11'd0, c_f2 = 11'd0, c_w = 11'd0, c_st = 11'd0;
  logic [10:0] c_aw = 11'd0, c_ah = 11'd0, c_off = 11'd0;
  logic hsync, vsync, field, active;
  logic [10:0] pix_x, pix_y;

  always #5 clk = ~clk;

  sd_raster_gen #(.HSYNC_W(HS_W), .VSYNC_LINES(VS_L)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_625(mode_625), .cfg_override(cfg_override),
    .cfg_frame_len(c_len), .cfg_f2_start(c_f2), .cfg_line_width(c_w),
    .cfg_act_start(c_st), .cfg_act_width(c_aw), .cfg_act_height(c_ah),
    .cfg_line_off(c_off),
    .hsync(hsync), .vsync(vsync), .field(field), .active(active),
    .pix_x(pix_x), .pix_y(pix_y));

  typedef struct { int len, f2, w, st, aw, ah, off; } mcfg_t;

  int n_chk = 0, n_bad = 0;
  bit done = 0, model_on = 0;
  int m_hc, m_vc;
  mcfg_t m_cfg;
  int max_px, act_x, act_y;

  function automatic mcfg_t pick_cfg();
    mcfg_t c;
    if (cfg_override) c = '{int'(c_len), int'(c_f2), int'(c_w), int'(c_st),
                            int'(c_aw), int'(c_ah), int'(c_off)};
    else if (mode_625) c = '{625, 311, 864, 144, 720, 288, 23};
    else c = '{525, 264, 858, 138, 720, 240, 20};
    return c;
  endfunction

  function automatic bit exp_active(int x, int y, mcfg_t c);
    bit h = (x >= c.st) && (x < c.st + c.aw);
    bit v = (y >= c.off && y < c.off + c.ah) ||
            (y >= c.f2 + c.off && y < c.f2 + c.off + c.ah);
    return h && v;
  endfunction

  function automatic bit exp_vsync(int y, mcfg_t c);
    return (y >= 1 && y < 1 + VS_L) || (y >= c.f2 && y < c.f2 + VS_L);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at t=%0t", req, act, exp, $time);
    end
  endtask

  // Reference raster following the requirements.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_hc = 0; m_vc = 1; m_cfg = pick_cfg(); model_on = 1;
    end else if (model_on) begin
      if (m_hc == m_cfg.w - 1 && m_vc == m_cfg.len) begin
        m_hc = 0; m_vc = 1; m_cfg = pick_cfg();
      end else if (m_hc == m_cfg.w - 1) begin
        m_hc = 0; m_vc++;
      end else m_hc++;
    end
  end

  always @(negedge clk) begin
    if (model_on && !done) begin
      check(int'(pix_x) == m_hc, "R1 pix_x", int'(pix_x), m_hc);
      check(int'(pix_y) == m_vc, "R1 pix_y", int'(pix_y), m_vc);
      check(field == (m_vc >= m_cfg.f2), "R2 field", field, m_vc >= m_cfg.f2);
      check(active == exp_active(m_hc, m_vc, m_cfg), "R3 active", active,
            exp_active(m_hc, m_vc, m_cfg));
      check(hsync == (m_hc < HS_W), "R4 hsync", hsync, m_hc < HS_W);
      check(vsync == exp_vsync(m_vc, m_cfg), "R5 vsync", vsync, exp_vsync(m_vc, m_cfg));
      if (int'(pix_x) > max_px) max_px = int'(pix_x);
      if (active && act_x < 0) begin act_x = int'(pix_x); act_y = int'(pix_y); end
    end
  end

  task automatic clear_track();
    max_px = -1; act_x = -1; act_y = -1;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rand_cfg();
    int w, st, len, f2, off, hmax;
    w = 16 + int'($urandom % 24);
    st = 2 + int'($urandom % 4);
    len = 16 + int'($urandom % 14);
    f2 = len / 2 + 1;
    off = 2 + int'($urandom % 2);
    hmax = (f2 - off < len - f2 - off + 1) ? f2 - off : len - f2 - off + 1;
    c_w = 11'(w); c_st = 11'(st); c_len = 11'(len); c_f2 = 11'(f2); c_off = 11'(off);
    c_aw = 11'(4 + int'($urandom % (w - st - 4)));
    c_ah = 11'(1 + int'($urandom % hmax));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cycles(3);
    // R10: origin loaded while reset is held
    check(pix_x == 11'd0 && pix_y == 11'd1, "R10 origin", int'(pix_y), 1);
    check(field == 1'b0 && vsync && hsync, "R10 sync state",
          {field, vsync, hsync}, 3);
    rst_n = 1'b1;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    clear_track();
    @(negedge clk);
    // R6: built-in 525/60 raster
    mode_625 = 1'b0; cfg_override = 1'b0;
    do_reset();
    clear_track();
    cycles(25 * 858);
    check(max_px == 857, "R6 line width", max_px, 857);
    check(act_x == 138 && act_y == 20, "R6 active origin", act_x * 1000 + act_y, 138020);
    // R9: mode change mid-frame must not alter the running frame
    mode_625 = 1'b1;
    clear_track();
    cycles(3 * 858);
    check(max_px == 857, "R9 mid-frame mode change", max_px, 857);
    check(int'(pix_y) > 25, "R9 frame continues", int'(pix_y), 26);
    // R7: built-in 625/50 raster, loaded through reset
    do_reset();
    clear_track();
    cycles(26 * 864);
    check(max_px == 863, "R7 line width", max_px, 863);
    check(act_x == 144 && act_y == 23, "R7 active origin", act_x * 1000 + act_y, 144023);
    // R8: port-supplied raster
    cfg_override = 1'b1;
    rand_cfg();
    do_reset();
    clear_track();
    cycles(int'(c_w) * 2);
    check(max_px == int'(c_w) - 1, "R8 custom width", max_px, int'(c_w) - 1);
    // Random rasters with mid-frame changes and occasional resets (R1-R5, R9)
    for (int k = 0; k < 40; k++) begin
      cycles(1 + int'($urandom % 1200));
      rand_cfg();
      mode_625 = $urandom % 2;
      if (k % 9 == 4) do_reset();
    end
    cycles(2500);
    // R8: standard mode again after override
    cfg_override = 1'b0; mode_625 = 1'b0;
    do_reset();
    clear_track();
    cycles(860);
    check(max_px == 857, "R8 override off", max_px, 857);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(190000 * 10);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule